// File: doc/BRIEF.md
# Interleaved Timing Skew Calibration Controller

This block sequences a foreground calibration of the sampling instants of an eight-way time-interleaved sampler. After a start request it steps through the neighbouring channel pairs (0,1), (1,2) and so on up to (6,7). For each pair it listens to the binary early/late decisions of a pair of comparator-based phase detectors. It counts those decisions in two windows of equal length. Between the two windows the swap output exchanges which physical detector looks at which channel of the pair. As a result, a detector that leans towards one answer adds the same amount to the early count and to the late count.

The late and early totals for the pair are compared against a deadband. The outcome is a step of one code (down, up or hold) for the upper channel of the pair. After every pair has been measured, the stored steps are written to the timing verniers of channels 1 to 7. These writes happen on consecutive cycles through a write strobe, an address and a code. Channel 0 is the timing reference and is never written. The whole measure-then-adjust pass repeats a fixed number of times. A one-cycle done pulse then marks the end of the run.

Top module: `skew_cal_ctrl`

## Requirements
- R1: After reset, busy, done and wr_en are low, and every vernier code held by the block equals the INIT parameter.
- R2: A start pulse while the block is idle makes busy high from the next cycle. Busy stays high until the run ends.
- R3: sel shows the lower channel of the pair being measured, ascending from 0 to NCH-2. Each pair takes two windows of WIN accepted decisions, the first with swap=0 and the second with swap=1. A decision is accepted only in a cycle with dec_vld high.
- R4: dec=1 means "late" while swap=0 and "early" while swap=1. The counts from both windows of a pair are added before any decision, so a detector stuck at one value yields equal late and early totals.
- R5: If the late total exceeds the early total by more than DB, the step for the upper channel is down. If the early total exceeds the late total by more than DB, the step is up. Otherwise the code holds.
- R6: After each pass, wr_en is high for NCH-1 consecutive cycles, with wr_addr rising from 1 to NCH-1. wr_code carries the stepped code for that channel. Address 0 is never written.
- R7: Codes saturate: a down step at 0 leaves 0, and an up step at 63 leaves 63.
- R8: A run makes ITERS passes. done is high for exactly one cycle, in the cycle after the final write, and busy is low in that cycle.
- R9: A start pulse while busy is high has no effect on the pair sequence or on the codes written.
- R10: Codes are kept between runs. A new run starts from the codes left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request, acted on only when idle |
| dec_vld | input | 1 | Qualifies dec in this cycle |
| dec | input | 1 | Raw phase detector decision |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sel | output | 3 | Lower channel of the pair being measured |
| swap | output | 1 | Detector assignment exchanged |
| wr_en | output | 1 | Vernier write strobe |
| wr_addr | output | 3 | Channel written |
| wr_code | output | 6 | New vernier code |

## Verification
The assertions place no constraint on start or dec_vld: start may arrive in any cycle, and decisions may be valid back to back or with gaps. The assertions rely only on the block's own sequencing of sel, the write strobe, the write address, busy and done. The stimulus drives dec_vld on alternate cycles and drives a flipped dec in the invalid cycles, so any decision counted without qualification would shift a total. It also raises start during a measurement window and during an adjust burst. The chosen per-pair late counts sit exactly on and just beyond the deadband edges, and repeated runs push codes into both saturation limits.

// File: rtl/skew_cal_ctrl.sv
module skew_cal_ctrl #(
  parameter int NCH   = 8,
  parameter int VW    = 6,
  parameter int ITERS = 3,
  parameter int WIN   = 1024,
  parameter int DB    = 4,
  parameter int INIT  = 32,
  localparam int AW   = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dec_vld,
  input  logic          dec,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] sel,
  output logic          swap,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [VW-1:0] wr_code
);
  localparam int NW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int CW = $clog2(2 * WIN + DB + 1);
  localparam int IW = $clog2(ITERS + 1);
  localparam logic [1:0] UP = 2'b01, DN = 2'b10, HOLD = 2'b00;

  typedef enum logic [1:0] {IDLE, MEAS, ADJ} st_t;

  st_t           st;
  logic [NW-1:0] n;
  logic          h;
  logic [AW-1:0] p, a;
  logic [IW-1:0] it;
  logic [CW-1:0] late_c, early_c, late_nx, early_nx;
  logic [VW-1:0] vern [NCH];
  logic [1:0]    stp  [NCH];
  logic          eff, take, win_end, go_dn, go_up;
  logic [VW-1:0] cur;

  assign busy    = (st != IDLE);
  assign sel     = p;
  assign swap    = h;
  assign wr_en   = (st == ADJ);
  assign wr_addr = a;

  assign eff      = dec ^ h;
  assign take     = (st == MEAS) && dec_vld;
  assign win_end  = take && (n == NW'(WIN - 1));
  assign late_nx  = late_c + CW'(eff);
  assign early_nx = early_c + CW'(!eff);
  assign go_dn    = late_nx > early_nx + CW'(DB);
  assign go_up    = early_nx > late_nx + CW'(DB);

  assign cur     = vern[a];
  assign wr_code = (stp[a] == UP && cur != {VW{1'b1}}) ? cur + 1'b1 :
                   (stp[a] == DN && cur != '0)         ? cur - 1'b1 : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      done    <= 1'b0;
      n       <= '0;
      h       <= 1'b0;
      p       <= '0;
      a       <= '0;
      it      <= '0;
      late_c  <= '0;
      early_c <= '0;
      for (int i = 0; i < NCH; i++) begin
        vern[i] <= VW'(INIT);
        stp[i]  <= HOLD;
      end
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st      <= MEAS;
          n       <= '0;
          h       <= 1'b0;
          p       <= '0;
          it      <= '0;
          late_c  <= '0;
          early_c <= '0;
        end
        MEAS: if (take) begin
          n       <= n + 1'b1;
          late_c  <= late_nx;
          early_c <= early_nx;
          if (win_end) begin
            n <= '0;
            if (!h) begin
              h <= 1'b1;
            end else begin
              h       <= 1'b0;
              late_c  <= '0;
              early_c <= '0;
              stp[p + 1'b1] <= go_dn ? DN : (go_up ? UP : HOLD);
              if (p == AW'(NCH - 2)) begin
                st <= ADJ;
                a  <= AW'(1);
              end else begin
                p <= p + 1'b1;
              end
            end
          end
        end
        ADJ: begin
          vern[a] <= wr_code;
          if (a == AW'(NCH - 1)) begin
            if (it == IW'(ITERS - 1)) begin
              st   <= IDLE;
              done <= 1'b1;
            end else begin
              it <= it + 1'b1;
              st <= MEAS;
              p  <= '0;
            end
          end else begin
            a <= a + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/skew_cal_chk.sv
module skew_cal_chk #(
  parameter int NCH = 8,
  parameter int VW  = 6,
  localparam int AW = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] sel,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [VW-1:0] wr_code
);
  // R6
  ref_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr != '0) && busy);

  // R6
  write_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !wr_en);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_last_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && ($past(wr_addr) == AW'(NCH - 1)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> busy || done);

  // R3
  pair_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !wr_en |-> sel <= AW'(NCH - 2));
endmodule

bind skew_cal_ctrl skew_cal_chk #(.NCH(NCH), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sel(sel), .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code)
);

// File: tb/sim_skew_cal_ctrl.sv
module sim_skew_cal_ctrl;
  localparam int NCH = 8, WIN = 8, DB = 2, INIT = 2, ITERS = 3, VMAX = 63;

  logic clk = 0, rst_n = 0, start = 0, dec_vld = 0, dec = 0;
  logic busy, done, swap, wr_en;
  logic [2:0] sel, wr_addr;
  logic [5:0] wr_code;

  int total = 0, bad = 0;
  int model [NCH];
  int lv [NCH];
  bit stuck, poke;

  always #2 clk = ~clk;

  skew_cal_ctrl #(.NCH(NCH), .VW(6), .ITERS(ITERS), .WIN(WIN), .DB(DB), .INIT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_vld(dec_vld), .dec(dec),
    .busy(busy), .done(done), .sel(sel), .swap(swap),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_code(wr_code));

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int step_of(int ch);
    int late, diff;
    late = stuck ? WIN : lv[ch];
    diff = 2 * late - 2 * WIN;
    if (diff > DB) return -1;
    if (-diff > DB) return 1;
    return 0;
  endfunction

  task automatic run_cal();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R2 busy", busy, 1);
    for (int it = 0; it < ITERS; it++) begin
      for (int p = 0; p < NCH - 1; p++)
        for (int h = 0; h < 2; h++)
          for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            if (k == 0) begin
              chk("R3 sel", sel, p);
              chk("R3 swap", swap, h);
            end
            dec_vld = 1;
            dec = stuck ? 1'b1 : (((h * WIN + k) < lv[p + 1]) ^ h[0]);
            if (poke && it == 1 && p == 3 && k == 2) start = 1;
            @(negedge clk);
            dec_vld = 0;
            dec = ~dec;
            start = 0;
          end
      for (int c = 1; c < NCH; c++) begin
        int e;
        e = model[c] + step_of(c);
        if (e < 0) e = 0;
        if (e > VMAX) e = VMAX;
        chk("R6 wr_en", wr_en, 1);
        chk("R6 wr_addr", wr_addr, c);
        chk("R5 R7 wr_code", wr_code, e);
        model[c] = e;
        if (poke && it == 0 && c == 3) start = 1;
        if (c < NCH - 1) begin
          @(negedge clk);
          start = 0;
        end
      end
      @(negedge clk);
      start = 0;
      if (it == ITERS - 1) begin
        chk("R8 done", done, 1);
        chk("R8 busy", busy, 0);
        @(negedge clk);
        chk("R8 done pulse", done, 0);
      end else begin
        chk("R8 no early done", done, 0);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 wr_en", wr_en, 0);
  endtask

  task automatic t_offset_cancel();
    stuck = 1; poke = 1;
    run_cal();
    for (int c = 1; c < NCH; c++) chk("R4 R9 R10 code held at INIT", model[c], INIT);
    stuck = 0; poke = 0;
  endtask

  task automatic t_all_late();
    for (int c = 0; c < NCH; c++) lv[c] = 2 * WIN;
    run_cal();
    chk("R7 low saturation", model[1], 0);
  endtask

  task automatic t_deadband();
    lv[1] = 9; lv[2] = 10; lv[3] = 7; lv[4] = 6;
    lv[5] = 16; lv[6] = 0; lv[7] = 8;
    run_cal();
    chk("R5 hold at edge", model[1], 0);
    chk("R5 R10 up", model[4], 3);
  endtask

  task automatic t_high_sat();
    bit hit;
    for (int c = 0; c < NCH; c++) lv[c] = 0;
    hit = 0;
    for (int r = 0; r < 30 && !hit; r++) begin
      hit = 1;
      for (int c = 1; c < NCH; c++) if (model[c] < VMAX) hit = 0;
      run_cal();
    end
    for (int c = 1; c < NCH; c++) chk("R7 high saturation", model[c], VMAX);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) model[c] = INIT;
    stuck = 0; poke = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_offset_cancel();
    t_all_late();
    t_deadband();
    t_high_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule